// File: doc/BRIEF.md
# Local Scan Port Router

This block sits between a backplane test port and three local scan rings on a board. A select register picks which local rings join the backplane scan path. With no ring picked, a one-bit bypass stage sits in the path. With one ring picked, that ring is inserted alone. With two or three rings picked, they are chained in series. The select register changes only on the update strobe that the backplane TAP issues in its Update-DR state, so the path never changes in the middle of a shift.

Each local ring can be parked in a stable TAP state while the backplane keeps clocking. A parked ring receives a constant TMS level that holds it in the parked state, and it drops out of the data path. A release request takes effect only when the backplane TAP reports the same stable state, so the local and backplane controllers stay in step. If the request arrives early, it stays pending until the states match. A separate enable input switches the pad drivers of all local ports off, so that a second test master can take control of the rings.

Top module: `scan_port_router`

## Requirements
- R1: After reset the select register is 3'b000, no port is parked, `tdo_ret` is 0, and each `lp_tms[i]` equals `tms`.
- R2: `sel_in` is copied into the select register at a rising clock edge where `sel_upd` is 1. At every other edge the register keeps its value. Bit i set means port i is picked.
- R3: Active ports (picked and not parked) are chained in ascending index order. The lowest active port's `lp_tdi` equals `tdi`. Each further active port's `lp_tdi` equals `lp_ret` of the next lower active port. `tdo_ret` equals `lp_ret` of the highest active port.
- R4: With exactly one active port i, `lp_tdi[i]` equals `tdi` and `tdo_ret` equals `lp_ret[i]`.
- R5: With no active port, `tdo_ret` after a rising edge equals the `tdi` value sampled at that edge.
- R6: A `park_req` at a rising edge parks every currently picked port in the state given by `park_code` (0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Pause-DR, 3 Pause-IR). A parked port's `lp_tms` is 1 for code 0 and 0 for the other codes, whatever the value of `tms`.
- R7: A parked port is treated as inactive in the data path, even while it is still picked.
- R8: An `unpark_req` releases parked ports only at an edge where `bp_stable` is 1 and `bp_state` equals the port's park code. If the codes do not match, the request stays pending and releases the port at the first later edge where they do.
- R9: `lp_drive` is 3'b111 while `out_en` is 1 and 3'b000 while it is 0.
- R10: Each `lp_tck[i]` follows `clk` at all times, parked or not.
- R11: `lp_ret` of an inactive port has no effect on `tdo_ret`. The `lp_tdi` of an inactive port is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Backplane serial data in |
| tms | input | 1 | Backplane mode select |
| sel_in | input | 3 | New port select value |
| sel_upd | input | 1 | Update-DR strobe that loads `sel_in` |
| park_req | input | 1 | Park the picked ports |
| park_code | input | 2 | Stable state to park in |
| unpark_req | input | 1 | Release request for parked ports |
| bp_stable | input | 1 | Backplane TAP is in a stable state |
| bp_state | input | 2 | Code of that backplane stable state |
| out_en | input | 1 | Drive enable for local port pads |
| lp_ret | input | 3 | Serial return from each local ring |
| lp_tdi | output | 3 | Serial data toward each local ring |
| lp_tms | output | 3 | Mode select toward each local ring |
| lp_tck | output | 3 | Clock toward each local ring |
| lp_drive | output | 3 | Pad drive enable per local port |
| tdo_ret | output | 1 | Serial return toward the bridge |

## Verification
The routing is driven with every select value: none, each single port, each pair, and all three. For each value, several return patterns are applied, so a swapped chain order, a wrong tail port, or a leak from an inactive ring each shows up as a wrong `tdi` or `tdo_ret` bit. The park tests use a park code that pulls TMS low against a TMS input of 1, and a code that pulls it high against an input of 0, so a port that is not really held is exposed. The release tests first present a mismatched backplane state and then the matching one, which separates an immediate release from a pending one. A toggling bypass input stream tells the one-cycle bypass delay apart from a direct connection.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;
  parameter int unsigned NUM_PORTS = 3;
  parameter int unsigned CODE_W    = 2;

  typedef enum logic [CODE_W-1:0] {
    ST_RESET = 2'd0,
    ST_IDLE  = 2'd1,
    ST_PDR   = 2'd2,
    ST_PIR   = 2'd3
  } stable_e;
endpackage

// File: rtl/port_park_ctrl.sv
module port_park_ctrl
  import scan_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              picked,
  input  logic              park_req,
  input  logic [CODE_W-1:0] park_code,
  input  logic              unpark_req,
  input  logic              bp_stable,
  input  logic [CODE_W-1:0] bp_state,
  input  logic              tms,
  output logic              parked,
  output logic              port_tms
);
  logic              parked_q, parked_d;
  logic              pend_q, pend_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              match, want, upd_en;

  assign match  = bp_stable && (bp_state == code_q);
  assign want   = pend_q || unpark_req;
  assign upd_en = park_req || parked_q;

  always_comb begin
    parked_d = parked_q;
    pend_d   = pend_q;
    code_d   = code_q;
    if (park_req && picked) begin
      parked_d = 1'b1;
      pend_d   = 1'b0;
      code_d   = park_code;
    end else if (parked_q) begin
      if (want && match) begin
        parked_d = 1'b0;
        pend_d   = 1'b0;
      end else begin
        pend_d = want;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parked_q <= 1'b0;
      pend_q   <= 1'b0;
      code_q   <= ST_RESET;
    end else if (upd_en) begin
      parked_q <= parked_d;
      pend_q   <= pend_d;
      code_q   <= code_d;
    end
  end

  assign parked   = parked_q;
  assign port_tms = parked_q ? (code_q == ST_RESET) : tms;

  AST_PARK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (park_req && picked) |=> parked) else $error("park"); // R6
  AST_UNPARK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(parked_q) |-> ($past(bp_stable) && ($past(bp_state) == $past(code_q)))) else $error("unpark"); // R8
endmodule

// File: rtl/chain_route.sv
module chain_route
  import scan_port_pkg::*;
(
  input  logic                 tdi,
  input  logic [NUM_PORTS-1:0] active,
  input  logic [NUM_PORTS-1:0] lp_ret,
  input  logic                 bypass_bit,
  output logic [NUM_PORTS-1:0] lp_tdi,
  output logic                 tdo_ret
);
  logic carry;

  always_comb begin
    carry = tdi;
    for (int i = 0; i < NUM_PORTS; i++) begin
      lp_tdi[i] = active[i] ? carry : 1'b1;
      if (active[i]) carry = lp_ret[i];
    end
    tdo_ret = (|active) ? carry : bypass_bit;
  end
endmodule

// File: rtl/scan_port_router.sv
module scan_port_router
  import scan_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tdi,
  input  logic       tms,
  input  logic [2:0] sel_in,
  input  logic       sel_upd,
  input  logic       park_req,
  input  logic [1:0] park_code,
  input  logic       unpark_req,
  input  logic       bp_stable,
  input  logic [1:0] bp_state,
  input  logic       out_en,
  input  logic [2:0] lp_ret,
  output logic [2:0] lp_tdi,
  output logic [2:0] lp_tms,
  output logic [2:0] lp_tck,
  output logic [2:0] lp_drive,
  output logic       tdo_ret
);
  logic [NUM_PORTS-1:0] sel_q, sel_d;
  logic [NUM_PORTS-1:0] parked;
  logic [NUM_PORTS-1:0] active;
  logic                 byp_q;

  always_comb begin
    sel_d = sel_q;
    if (sel_upd) sel_d = sel_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (sel_upd) sel_q <= sel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b0;
    else        byp_q <= tdi;
  end

  generate
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
      port_park_ctrl u_park (
        .clk        (clk),
        .rst_n      (rst_n),
        .picked     (sel_q[g]),
        .park_req   (park_req),
        .park_code  (park_code),
        .unpark_req (unpark_req),
        .bp_stable  (bp_stable),
        .bp_state   (bp_state),
        .tms        (tms),
        .parked     (parked[g]),
        .port_tms   (lp_tms[g])
      );
      assign lp_tck[g]   = clk;
      assign lp_drive[g] = out_en;
    end
  endgenerate

  assign active = sel_q & ~parked;

  chain_route u_route (
    .tdi        (tdi),
    .active     (active),
    .lp_ret     (lp_ret),
    .bypass_bit (byp_q),
    .lp_tdi     (lp_tdi),
    .tdo_ret    (tdo_ret)
  );

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_upd |=> $stable(sel_q)) else $error("sel"); // R2
  AST_BYPASS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |=> ((active != '0) || (tdo_ret == $past(tdi)))) else $error("bypass"); // R5
endmodule

// File: tb/tb_scan_port_router.sv
module tb_scan_port_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tdi = 1'b0, tms = 1'b0;
  logic [2:0] sel_in = '0;
  logic       sel_upd = 1'b0, park_req = 1'b0, unpark_req = 1'b0;
  logic [1:0] park_code = '0, bp_state = '0;
  logic       bp_stable = 1'b0, out_en = 1'b1;
  logic [2:0] lp_ret = '0;
  logic [2:0] lp_tdi, lp_tms, lp_tck, lp_drive;
  logic       tdo_ret;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  scan_port_router dut (
    .clk(clk), .rst_n(rst_n), .tdi(tdi), .tms(tms), .sel_in(sel_in),
    .sel_upd(sel_upd), .park_req(park_req), .park_code(park_code),
    .unpark_req(unpark_req), .bp_stable(bp_stable), .bp_state(bp_state),
    .out_en(out_en), .lp_ret(lp_ret), .lp_tdi(lp_tdi), .lp_tms(lp_tms),
    .lp_tck(lp_tck), .lp_drive(lp_drive), .tdo_ret(tdo_ret)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_sel(input logic [2:0] v);
    sel_in = v; sel_upd = 1'b1;
    tick();
    sel_upd = 1'b0;
  endtask

  // expected routing for an active set, from R3/R4/R11
  task automatic route_check(input string req, input logic [2:0] act);
    logic       c;
    logic [2:0] et;
    c = tdi;
    for (int i = 0; i < 3; i++) begin
      et[i] = act[i] ? c : 1'b1;
      if (act[i]) c = lp_ret[i];
    end
    #1;
    chk(req, {1'b0, lp_tdi}, {1'b0, et});
    if (act != 3'b000) chk(req, {3'b0, tdo_ret}, {3'b0, c});
  endtask

  task automatic t_reset();
    tms = 1'b1; #1;
    chk("R1", {1'b0, lp_tms}, 4'b0111);
    chk("R1", {3'b0, tdo_ret}, 4'b0000);
    tms = 1'b0; #1;
    chk("R1", {1'b0, lp_tms}, 4'b0000);
  endtask

  task automatic t_sel_load();
    sel_in = 3'b001; sel_upd = 1'b0;
    tick();
    tdi = 1'b0; lp_ret = 3'b111; #1;
    chk("R2", {1'b0, lp_tdi}, 4'b0111); // still bypass
    load_sel(3'b001);
    tdi = 1'b0; #1;
    chk("R2", {1'b0, lp_tdi}, 4'b0110);
  endtask

  task automatic t_routes();
    for (int m = 1; m < 8; m++) begin
      load_sel(m[2:0]);
      for (int p = 0; p < 8; p += 3) begin
        lp_ret = p[2:0]; tdi = p[0];
        route_check((m == 1 || m == 2 || m == 4) ? "R4" : "R3", m[2:0]);
        tdi = ~tdi; lp_ret = ~lp_ret;
        route_check("R3", m[2:0]);
      end
    end
    load_sel(3'b010);
    tdi = 1'b1; lp_ret = 3'b010; #1;
    chk("R11", {3'b0, tdo_ret}, 4'b0001);
    lp_ret = 3'b101; #1;
    chk("R11", {3'b0, tdo_ret}, 4'b0000);
  endtask

  task automatic t_bypass();
    load_sel(3'b000);
    for (int k = 0; k < 6; k++) begin
      logic b;
      b = (k % 3) != 0;
      tdi = b; lp_ret = {3{~b}};
      tick();
      tdi = ~b; #1;
      chk("R5", {3'b0, tdo_ret}, {3'b0, b});
    end
  endtask

  task automatic t_park_unpark();
    load_sel(3'b011);
    tms = 1'b1; park_code = 2'd2; park_req = 1'b1;
    tick();
    park_req = 1'b0; #1;
    chk("R6", {1'b0, lp_tms}, 4'b0100);
    tdi = 1'b1; lp_ret = 3'b000;
    tick();
    tdi = 1'b0; #1;
    chk("R7", {3'b0, tdo_ret}, 4'b0001);
    chk("R7", {1'b0, lp_tdi}, 4'b0111);
    bp_stable = 1'b1; bp_state = 2'd1; unpark_req = 1'b1;
    tick();
    unpark_req = 1'b0; #1;
    chk("R8", {1'b0, lp_tms}, 4'b0100);
    tick(); #1;
    chk("R8", {1'b0, lp_tms}, 4'b0100);
    bp_state = 2'd2;
    tick(); #1;
    chk("R8", {1'b0, lp_tms}, 4'b0111);
    tdi = 1'b1; lp_ret = 3'b010;
    route_check("R8", 3'b011);
    tms = 1'b0; park_code = 2'd0; park_req = 1'b1;
    tick();
    park_req = 1'b0; #1;
    chk("R6", {1'b0, lp_tms}, 4'b0011);
    bp_state = 2'd0; unpark_req = 1'b1;
    tick();
    unpark_req = 1'b0; #1;
    chk("R8", {1'b0, lp_tms}, 4'b0000);
    bp_stable = 1'b0;
  endtask

  task automatic t_drive_clock();
    out_en = 1'b1; #1;
    chk("R9", {1'b0, lp_drive}, 4'b0111);
    out_en = 1'b0; #1;
    chk("R9", {1'b0, lp_drive}, 4'b0000);
    out_en = 1'b1;
    @(posedge clk); #1;
    chk("R10", {1'b0, lp_tck}, 4'b0111);
    @(negedge clk); #1;
    chk("R10", {1'b0, lp_tck}, 4'b0000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_sel_load();
        t_routes();
        t_bypass();
        t_park_unpark();
        t_drive_clock();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule